// File: doc/BRIEF.md
# Automatic RTS/CTS flow controller

This block provides hardware flow control for a single serial channel whose receive and transmit paths are buffered. On the receive side it drives the active-low RTS line from the fill level of the receive buffer. Once the buffer holds enough characters, RTS is withdrawn so the far end pauses. RTS is offered again after the host has drained the buffer. On the transmit side it gives the transmit shifter a start permit that follows the remote CTS line, so a new character is not launched while the peer is not ready.

Four trigger settings select the receive threshold. The three lower settings release RTS as soon as the buffer count reaches the selected level. They reassert it only when the host reads the last byte held, which gives hysteresis. The highest setting acts later: RTS is withdrawn when the first data bit of the character that would fill the last slot arrives, and it comes back on the next data read. CTS is synchronized first. It is sampled against the transmitter's stop-bit midpoint tick, so the character in progress always completes. When CTS returns, the permit is restored a few clocks later and does not wait for another tick.

Top module: `rtscts_flow`

## Requirements
- R1: While rst is high at a clock edge, rts_n is 1 and tx_permit is 1 after that edge.
- R2: With auto_rts_en=1, rts_bit=1, loop_en=0 and trig_sel in {0,1,2}, rts_n becomes 1 one clock after rx_count reaches or exceeds the level. The levels are 1 for trig_sel=0, DEPTH/4 for trig_sel=1 and DEPTH/2 for trig_sel=2.
- R3: In the modes of R2, once withdrawn, RTS stays inactive (rts_n=1) through reads made with rx_count>1. It returns active (rts_n=0) one clock after rx_read is pulsed while rx_count==1, which is the read of the last byte.
- R4: With trig_sel=3, rx_count alone never withdraws RTS. rts_n becomes 1 one clock after rx_char_start is pulsed while rx_count==DEPTH-1.
- R5: With trig_sel=3, after RTS has been withdrawn, any rx_read makes rts_n 0 one clock later, whatever the count.
- R6: loop_en=1 or rts_bit=0 drives rts_n to 1 one clock later, regardless of the buffer level.
- R7: With auto_rts_en=0, rts_n equals the inverse of rts_bit one clock later, and rx_count, rx_read and rx_char_start have no effect.
- R8: With auto_cts_en=1, tx_permit falls only one clock after a tx_stop_mid pulse that finds the synchronized cts_n high. cts_n going high without a tick leaves tx_permit at 1, and a tick with cts_n low keeps it at 1.
- R9: With auto_cts_en=1 and tx_permit=0, tx_permit returns to 1 within SYNC_STAGES+1 clocks of cts_n going low, without any tick.
- R10: With auto_cts_en=0, tx_permit is 1 one clock later and stays 1 whatever cts_n and tx_stop_mid do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | $clog2(DEPTH+1) | Characters held in the receive buffer |
| trig_sel | input | 2 | Receive trigger setting, 0 to 3 |
| rx_char_start | input | 1 | One-clock strobe at the first data bit of an incoming character |
| rx_read | input | 1 | One-clock strobe when the host reads a receive byte |
| cts_n | input | 1 | Remote clear-to-send, active low, asynchronous |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| auto_cts_en | input | 1 | Enables CTS gating of the transmitter |
| rts_bit | input | 1 | Manual request-to-send control bit |
| loop_en | input | 1 | Loopback operation, which forces RTS inactive |
| tx_stop_mid | input | 1 | Tick at the midpoint of the stop bit being transmitted |
| rts_n | output | 1 | Request-to-send, active low |
| tx_permit | output | 1 | Permit for the transmit shifter to start the next character |

## Verification
The bench builds the block with DEPTH=16 and SYNC_STAGES=2. At these values the three count thresholds are 1, 4 and 8, and the high-setting trigger sits at a count of 15, all reachable with a 5-bit count. The CTS resume window is three clocks, so the bench can wait it out directly. Directed sequences cover the hysteresis, mode-change and CTS tick corners. A long random run mixes every trigger setting with reads, character starts, loopback and enable changes.

// File: rtl/rtscts_pkg.sv
package rtscts_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_HIGH    = 2'd3
    } trig_e;

    typedef struct packed {
        logic read;
        logic char_start;
    } rx_evt_t;

    typedef struct packed {
        logic manual_rts;
        logic auto_rts;
        logic loop;
    } rts_ctl_t;

    // Count level at which the lower trigger settings withdraw RTS.
    function automatic int unsigned trig_level(trig_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 1;
        endcase
    endfunction

endpackage

// File: rtl/rtscts_sync.sv
module rtscts_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtscts_rts_ctl.sv
module rtscts_rts_ctl
    import rtscts_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  trig_e         trig_sel,
    input  rx_evt_t       evt,
    input  rts_ctl_t      ctl,
    output logic          rts_n
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(1);

    logic [CW-1:0] lvl;
    logic          armed;
    logic          hold_q;
    logic          hold_d;

    assign lvl   = CW'(trig_level(trig_sel, DEPTH));
    assign armed = ctl.manual_rts & ctl.auto_rts;

    always_comb begin
        hold_d = hold_q;
        if (!armed) begin
            hold_d = 1'b0;
        end else if (trig_sel == TRIG_HIGH) begin
            if (evt.read)
                hold_d = 1'b0;
            else if (evt.char_start && rx_count == LAST_SLOT)
                hold_d = 1'b1;
        end else begin
            if (evt.read && rx_count == ONE_LEFT)
                hold_d = 1'b0;
            else if (rx_count >= lvl)
                hold_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            rts_n  <= 1'b1;
        end else begin
            hold_q <= hold_d;
            rts_n  <= ~(ctl.manual_rts & ~ctl.loop & ~(ctl.auto_rts & hold_d));
        end
    end

    p_thresh_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.auto_rts && ctl.manual_rts && !ctl.loop && trig_sel != TRIG_HIGH &&
         rx_count >= lvl && !(evt.read && rx_count == ONE_LEFT)) |=> rts_n);

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.auto_rts && ctl.manual_rts && !ctl.loop && trig_sel != TRIG_HIGH &&
         evt.read && rx_count == ONE_LEFT) |=> !rts_n);

    p_high_release_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.auto_rts && ctl.manual_rts && !ctl.loop && trig_sel == TRIG_HIGH &&
         evt.read) |=> !rts_n);

    p_forced_off_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.loop || !ctl.manual_rts) |=> rts_n);

    p_manual_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.auto_rts && !ctl.loop) |=> (rts_n == !$past(ctl.manual_rts)));
endmodule

// File: rtl/rtscts_cts_gate.sv
module rtscts_cts_gate (
    input  logic clk,
    input  logic rst,
    input  logic auto_cts,
    input  logic cts_sync_n,
    input  logic stop_mid,
    output logic tx_permit
);
    logic cts_active;
    assign cts_active = ~cts_sync_n;

    always_ff @(posedge clk) begin
        if (rst)
            tx_permit <= 1'b1;
        else if (!auto_cts)
            tx_permit <= 1'b1;
        else if (!tx_permit && cts_active)
            tx_permit <= 1'b1;
        else if (stop_mid)
            tx_permit <= cts_active;
    end

    p_drop_at_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (auto_cts && tx_permit && !stop_mid) |=> tx_permit);

    p_resume_r9: assert property (@(posedge clk) disable iff (rst)
        (auto_cts && !tx_permit && !cts_sync_n) |=> tx_permit);

    p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !auto_cts |=> tx_permit);
endmodule

// File: rtl/rtscts_flow.sv
module rtscts_flow
    import rtscts_pkg::*;
#(
    parameter  int unsigned DEPTH       = 16,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned CW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  logic [1:0]    trig_sel,
    input  logic          rx_char_start,
    input  logic          rx_read,
    input  logic          cts_n,
    input  logic          auto_rts_en,
    input  logic          auto_cts_en,
    input  logic          rts_bit,
    input  logic          loop_en,
    input  logic          tx_stop_mid,
    output logic          rts_n,
    output logic          tx_permit
);
    rx_evt_t  evt;
    rts_ctl_t ctl;
    logic     cts_sync_n;

    assign evt = '{read: rx_read, char_start: rx_char_start};
    assign ctl = '{manual_rts: rts_bit, auto_rts: auto_rts_en, loop: loop_en};

    rtscts_rts_ctl #(.DEPTH(DEPTH)) u_rts (
        .clk      (clk),
        .rst      (rst),
        .rx_count (rx_count),
        .trig_sel (trig_e'(trig_sel)),
        .evt      (evt),
        .ctl      (ctl),
        .rts_n    (rts_n)
    );

    rtscts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
        .clk (clk),
        .rst (rst),
        .d   (cts_n),
        .q   (cts_sync_n)
    );

    rtscts_cts_gate u_cts (
        .clk        (clk),
        .rst        (rst),
        .auto_cts   (auto_cts_en),
        .cts_sync_n (cts_sync_n),
        .stop_mid   (tx_stop_mid),
        .tx_permit  (tx_permit)
    );

    p_reset_r1: assert property (@(posedge clk) rst |=> (rts_n && tx_permit));
endmodule

// File: tb/rtscts_flow_bench.sv
module rtscts_flow_bench;
    localparam int unsigned DEPTH      = 16;
    localparam int unsigned CW         = $clog2(DEPTH + 1);
    localparam int          CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] rx_count;
    logic [1:0]    trig_sel;
    logic          rx_char_start, rx_read, cts_n;
    logic          auto_rts_en, auto_cts_en, rts_bit, loop_en, tx_stop_mid;
    logic          rts_n, tx_permit;

    int total = 0;
    int bad   = 0;
    logic m_hold = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtscts_flow #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_rtscts_flow (
        .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
        .rx_char_start(rx_char_start), .rx_read(rx_read), .cts_n(cts_n),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .rts_bit(rts_bit),
        .loop_en(loop_en), .tx_stop_mid(tx_stop_mid), .rts_n(rts_n), .tx_permit(tx_permit)
    );

    function automatic int unsigned level_of(logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return DEPTH / 4;
            2'd2:    return DEPTH / 2;
            default: return DEPTH - 1;
        endcase
    endfunction

    // Next hold state from the requirement rules, given pre-edge inputs.
    function automatic logic next_hold(logic hold, logic [1:0] sel, int unsigned cnt,
                                       logic rd, logic cs, logic arm);
        if (!arm) return 1'b0;
        if (sel == 2'd3) begin
            if (rd) return 1'b0;
            if (cs && cnt == DEPTH - 1) return 1'b1;
            return hold;
        end
        if (rd && cnt == 1) return 1'b0;
        if (cnt >= level_of(sel)) return 1'b1;
        return hold;
    endfunction

    function automatic logic exp_rts_n(logic hold, logic man, logic lp, logic aut);
        return ~(man & ~lp & ~(aut & hold));
    endfunction

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_count = '0; trig_sel = 2'd0; rx_char_start = 1'b0; rx_read = 1'b0;
        cts_n = 1'b0; auto_rts_en = 1'b0; auto_cts_en = 1'b0; rts_bit = 1'b0;
        loop_en = 1'b0; tx_stop_mid = 1'b0;
        ticks(2);
        check("R1 rts_n in reset", rts_n, 1'b1);
        check("R1 tx_permit in reset", tx_permit, 1'b1);
        rst = 1'b0;

        // R2: threshold withdrawal, lowest setting
        auto_rts_en = 1'b1; rts_bit = 1'b1; trig_sel = 2'd0; rx_count = 0;
        tick();
        check("R2 empty buffer rts active", rts_n, 1'b0);
        rx_count = 1;
        tick();
        check("R2 level 1 reached", rts_n, 1'b1);

        // R3: release on last-byte read, then half setting
        trig_sel = 2'd2; rx_read = 1'b1; rx_count = 1;
        tick();
        rx_read = 1'b0; rx_count = 0;
        check("R3 last byte read releases", rts_n, 1'b0);
        rx_count = 7;
        tick();
        check("R2 below half level", rts_n, 1'b0);
        rx_count = 8;
        tick();
        check("R2 half level reached", rts_n, 1'b1);
        rx_count = 5; rx_read = 1'b1;
        tick();
        check("R3 read with bytes left keeps hold", rts_n, 1'b1);
        rx_count = 1;
        tick();
        rx_read = 1'b0; rx_count = 0;
        check("R3 final read releases", rts_n, 1'b0);

        // R4/R5: highest setting
        trig_sel = 2'd3; rx_count = 10;
        tick();
        check("R4 count alone no effect", rts_n, 1'b0);
        rx_count = DEPTH - 1; rx_char_start = 1'b1;
        tick();
        rx_char_start = 1'b0;
        check("R4 char start on last slot", rts_n, 1'b1);
        tick();
        check("R4 hold persists", rts_n, 1'b1);
        rx_read = 1'b1;
        tick();
        rx_read = 1'b0;
        check("R5 next read releases", rts_n, 1'b0);

        // R6: loopback and manual clear
        loop_en = 1'b1; rx_count = 0;
        tick();
        check("R6 loopback forces inactive", rts_n, 1'b1);
        loop_en = 1'b0;
        tick();
        check("R6 loopback removed", rts_n, 1'b0);
        rts_bit = 1'b0;
        tick();
        check("R6 manual bit cleared", rts_n, 1'b1);

        // R7: auto disabled
        auto_rts_en = 1'b0; rts_bit = 1'b1; trig_sel = 2'd0; rx_count = DEPTH;
        tick();
        check("R7 full buffer ignored", rts_n, 1'b0);
        rts_bit = 1'b0;
        tick();
        check("R7 follows manual bit", rts_n, 1'b1);

        // R8/R9: CTS gating
        auto_cts_en = 1'b1; cts_n = 1'b0;
        ticks(3);
        check("R8 cts active permit", tx_permit, 1'b1);
        tx_stop_mid = 1'b1;
        tick();
        tx_stop_mid = 1'b0;
        check("R8 tick with cts active keeps permit", tx_permit, 1'b1);
        cts_n = 1'b1;
        ticks(4);
        check("R8 cts inactive without tick", tx_permit, 1'b1);
        tx_stop_mid = 1'b1;
        tick();
        tx_stop_mid = 1'b0;
        check("R8 tick with cts inactive blocks", tx_permit, 1'b0);
        ticks(5);
        check("R8 stays blocked", tx_permit, 1'b0);
        cts_n = 1'b0;
        ticks(3);
        check("R9 resume after cts active", tx_permit, 1'b1);

        // R10: gating disabled
        cts_n = 1'b1;
        ticks(3);
        tx_stop_mid = 1'b1;
        tick();
        tx_stop_mid = 1'b0;
        check("R8 blocked again", tx_permit, 1'b0);
        auto_cts_en = 1'b0;
        tick();
        check("R10 disable restores permit", tx_permit, 1'b1);
        tx_stop_mid = 1'b1;
        tick();
        tx_stop_mid = 1'b0;
        check("R10 tick ignored when disabled", tx_permit, 1'b1);

        // Random mix for R2 to R7 against the bench model
        void'($urandom(32'h5eed_1234));
        rts_bit = 1'b0; auto_rts_en = 1'b0; loop_en = 1'b0;
        tick();
        m_hold = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] s;
            int unsigned c;
            logic rd, cs, lp, man, aut, nh;
            s   = 2'($urandom_range(0, 3));
            c   = $urandom_range(0, DEPTH);
            rd  = ($urandom_range(0, 3) == 0);
            cs  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 3) == 0) c = (s == 2'd3) ? DEPTH - 1 : 1;
            lp  = ($urandom_range(0, 15) == 0);
            man = ($urandom_range(0, 15) != 0);
            aut = ($urandom_range(0, 7) != 0);
            trig_sel = s; rx_count = CW'(c); rx_read = rd; rx_char_start = cs;
            loop_en = lp; rts_bit = man; auto_rts_en = aut;
            nh = next_hold(m_hold, s, c, rd, cs, man & aut);
            tick();
            m_hold = nh;
            check("R2-mix R3 R4 R5 R6 R7 random rts_n", rts_n, exp_rts_n(nh, man, lp, aut));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule